// File: doc/BRIEF.md
# Phase-Presettable Prescaled NCO Clock Generator

This block makes a square wave whose frequency is set by a phase increment added to a wide phase accumulator. The accumulator top bit is the output, so the wave is always at half duty. A prescaler slows the accumulator down: the increment is added only once in every divide-period cycles of the system clock. This gives two ways to set frequency, a coarse integer divider and a fine fractional step.

A configuration write loads the divide period and presets the upper half of the accumulator. The preset lets two generators run at a fixed phase offset from one another, for example a bit clock and a word clock whose word edge must lead the data by one bit time. After the write, the preset field has no further effect. The increment has its own write port. An enable starts and stops the generator. A one-cycle strobe marks every output edge produced by an add, so downstream logic can act on it.

The controller has two states. In `ST_OFF` the output is low, the accumulator is frozen and the prescale count is held at zero. In `ST_RUN` the prescaler counts and the accumulator advances. The `start` transition (`ST_OFF` to `ST_RUN`) is taken on a clock edge where `enable` is high. The `stop` transition (`ST_RUN` to `ST_OFF`) is taken on a clock edge where `enable` is low.

Top module: `nco_phase_clkgen`

## Requirements
- R1: After reset, `clk_out` and `edge_stb` are 0, the accumulator and increment are 0, and the divide period is 0.
- R2: A configuration write loads `cfg_x[15:0]` as the divide period. It also loads `cfg_x[31:16]` into accumulator bits 31:16, clears accumulator bits 15:0 and clears the prescale count. A preset of 0x8000 therefore makes `clk_out` read 1 in the first running cycle.
- R3: An increment write stores `inc_val`. Every later add uses the stored value.
- R4: While running, the increment is added once every P enabled cycles. P is the divide period, and a period of 0 acts as 1. The first add happens on the P-th clock edge after the `start` edge.
- R5: `clk_out` equals accumulator bit 31 while in `ST_RUN`, and is 0 in `ST_OFF`. The state follows `enable` with one cycle of delay.
- R6: While `enable` is low, the accumulator holds its value and the prescale count is held at 0. On restart, the output resumes from the frozen phase.
- R7: `edge_stb` is high for exactly the one cycle after an add that changed accumulator bit 31, and is low otherwise.
- R8: A configuration write on the same edge as a due add takes precedence. No add happens and no strobe is raised on that edge, and counting restarts from zero.
- R9: With increment 0x8000_0000 and divide period P, `clk_out` toggles once every P running cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; high selects `ST_RUN` on the next edge |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_x | input | 32 | [15:0] divide period, [31:16] phase preset |
| inc_wr | input | 1 | Increment write strobe |
| inc_val | input | 32 | Phase increment value |
| clk_out | output | 1 | Generated half-duty clock |
| edge_stb | output | 1 | One-cycle strobe after each output edge caused by an add |

## Verification
The bench targets these corner cases, each of which has a clear failure mode:
- **Period of zero.** A design that mishandles it would stall, or wrap its counter through 65536 cycles, instead of adding every clock.
- **Start-up timing.** A prescaler that is not cleared at `start` would place the first add at a random point instead of P edges after the `start` edge.
- **Phase preset.** A preset written to the wrong half of the accumulator, or one that leaves stale low bits, shows up as a wrong first output level or a shifted edge.
- **Collision and stop/restart.** A configuration write that collides with a due add must suppress both the add and its strobe. A stop followed by a restart must resume from the frozen phase; a design that keeps adding while stopped would come back at a different output level.

// File: rtl/nco_pkg.sv
package nco_pkg;
    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } nco_state_e;
endpackage

// File: rtl/nco_prescaler.sv
module nco_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] load_val,
    input  logic             clr,
    input  logic             run,
    output logic             tick,
    output logic [DIV_W-1:0] cnt,
    output logic [DIV_W-1:0] lim
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] period_q;
    logic [DIV_W-1:0] cnt_q;

    // A period of zero behaves as one so the generator never stalls
    assign lim  = (period_q == '0) ? ONE : period_q;
    assign tick = run && (cnt_q == lim - ONE);
    assign cnt  = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= '0;
        end else if (load) begin
            period_q <= load_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= tick ? '0 : cnt_q + ONE;
        end
    end
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int ACC_W = 32,
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             preset,
    input  logic [DIV_W-1:0] preset_phase,
    input  logic             inc_wr,
    input  logic [ACC_W-1:0] inc_val,
    input  logic             step,
    output logic [ACC_W-1:0] acc,
    output logic             msb_flip
);
    localparam int LOW_W = ACC_W - DIV_W;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] inc_q;
    logic [ACC_W-1:0] sum;

    assign sum      = acc_q + inc_q;
    assign msb_flip = step && (sum[ACC_W-1] != acc_q[ACC_W-1]);
    assign acc      = acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (preset) begin
            acc_q <= ACC_W'(preset_phase) << LOW_W;
        end else if (step) begin
            acc_q <= sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inc_q <= '0;
        end else if (inc_wr) begin
            inc_q <= inc_val;
        end
    end
endmodule

// File: rtl/nco_phase_clkgen.sv
module nco_phase_clkgen
    import nco_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int DIV_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               cfg_wr,
    input  logic [2*DIV_W-1:0] cfg_x,
    input  logic               inc_wr,
    input  logic [ACC_W-1:0]   inc_val,
    output logic               clk_out,
    output logic               edge_stb
);
    nco_state_e       state_q;
    nco_state_e       state_d;
    logic             running;
    logic             cnt_clr;
    logic             cnt_run;
    logic             tick;
    logic             flip;
    logic             stb_q;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;
    logic [ACC_W-1:0] acc_q;

    // Next-state logic: start on enable high, stop on enable low
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (enable)  state_d = ST_RUN;
            ST_RUN: if (!enable) state_d = ST_OFF;
            default:             state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    assign running = (state_q == ST_RUN);
    assign cnt_run = running && enable && !cfg_wr;
    assign cnt_clr = cfg_wr || !enable || !running;

    nco_prescaler #(.DIV_W(DIV_W)) i_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_wr),
        .load_val (cfg_x[DIV_W-1:0]),
        .clr      (cnt_clr),
        .run      (cnt_run),
        .tick     (tick),
        .cnt      (cnt_q),
        .lim      (lim)
    );

    nco_phase_acc #(.ACC_W(ACC_W), .DIV_W(DIV_W)) i_acc (
        .clk          (clk),
        .rst_n        (rst_n),
        .preset       (cfg_wr),
        .preset_phase (cfg_x[2*DIV_W-1:DIV_W]),
        .inc_wr       (inc_wr),
        .inc_val      (inc_val),
        .step         (tick),
        .acc          (acc_q),
        .msb_flip     (flip)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_q <= 1'b0;
        end else begin
            stb_q <= flip;
        end
    end

    // Output process
    always_comb begin
        clk_out  = 1'b0;
        edge_stb = stb_q;
        unique case (state_q)
            ST_OFF:  clk_out = 1'b0;
            ST_RUN:  clk_out = acc_q[ACC_W-1];
            default: clk_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/nco_phase_clkgen_chk.sv
module nco_phase_clkgen_chk #(
    parameter int ACC_W = 32,
    parameter int DIV_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               enable,
    input logic               cfg_wr,
    input logic [2*DIV_W-1:0] cfg_x,
    input logic               clk_out,
    input logic               edge_stb,
    input logic [ACC_W-1:0]   acc,
    input logic [DIV_W-1:0]   cnt,
    input logic [DIV_W-1:0]   lim
);
    AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_wr) |-> (acc[ACC_W-1 -: DIV_W] == $past(cfg_x[2*DIV_W-1:DIV_W])
                           && acc[ACC_W-DIV_W-1:0] == '0 && cnt == '0)); // R2

    AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < lim); // R4

    AST_LOW_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!enable) |-> !clk_out); // R5

    AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!enable) && $past(!cfg_wr)) |-> ($stable(acc) && cnt == '0)); // R6

    AST_STB_IS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        edge_stb |-> (clk_out != $past(clk_out))); // R7

    AST_NO_STB_AFTER_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_wr) |-> !edge_stb); // R8
endmodule

bind nco_phase_clkgen nco_phase_clkgen_chk #(.ACC_W(ACC_W), .DIV_W(DIV_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .cfg_wr   (cfg_wr),
    .cfg_x    (cfg_x),
    .clk_out  (clk_out),
    .edge_stb (edge_stb),
    .acc      (acc_q),
    .cnt      (cnt_q),
    .lim      (lim)
);

// File: tb/test_nco_phase_clkgen.sv
module test_nco_phase_clkgen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_x = '0;
    logic        inc_wr = 1'b0;
    logic [31:0] inc_val = '0;
    logic        clk_out;
    logic        edge_stb;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit cmp_on = 1'b0;

    always #10 clk = ~clk;

    nco_phase_clkgen i_nco_phase_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .cfg_wr   (cfg_wr),
        .cfg_x    (cfg_x),
        .inc_wr   (inc_wr),
        .inc_val  (inc_val),
        .clk_out  (clk_out),
        .edge_stb (edge_stb)
    );

    // Reference model built from the requirements
    logic        m_on;
    logic [15:0] m_per;
    logic [15:0] m_cnt;
    logic [31:0] m_acc;
    logic [31:0] m_inc;
    logic        m_stb;
    logic [15:0] m_lim;
    logic [31:0] m_sum;
    assign m_lim = (m_per == 16'd0) ? 16'd1 : m_per;
    assign m_sum = m_acc + m_inc;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_on <= 1'b0; m_per <= '0; m_cnt <= '0;
            m_acc <= '0; m_inc <= '0; m_stb <= 1'b0;
        end else begin
            m_stb <= 1'b0;
            if (cfg_wr) begin
                m_per <= cfg_x[15:0];
                m_acc <= {cfg_x[31:16], 16'h0000};
                m_cnt <= '0;
            end else if (m_on && enable) begin
                if (m_cnt == m_lim - 16'd1) begin
                    m_acc <= m_sum;
                    m_cnt <= '0;
                    m_stb <= (m_sum[31] != m_acc[31]);
                end else begin
                    m_cnt <= m_cnt + 16'd1;
                end
            end else begin
                m_cnt <= '0;
            end
            if (inc_wr) m_inc <= inc_val;
            m_on <= enable;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk("R5 clk_out vs model", {31'd0, clk_out}, {31'd0, m_on & m_acc[31]});
            chk("R7 edge_stb vs model", {31'd0, edge_stb}, {31'd0, m_stb});
        end
    end

    task automatic write_cfg(input logic [31:0] x, input logic do_inc, input logic [31:0] inc,
                             input logic en);
        cfg_wr = 1'b1; cfg_x = x; inc_wr = do_inc; inc_val = inc; enable = en;
        @(negedge clk);
        cfg_wr = 1'b0; inc_wr = 1'b0;
    endtask

    task automatic count_stb(input int n, output int c);
        c = 0;
        repeat (n) begin
            @(negedge clk);
            c += int'(edge_stb);
        end
    endtask

    function automatic int toggles_expected(input int cycles, input int period);
        int p;
        p = (period == 0) ? 1 : period;
        return cycles / p;
    endfunction

    initial begin
        int c;
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        chk("R1 clk_out in reset", {31'd0, clk_out}, 32'd0);
        chk("R1 edge_stb in reset", {31'd0, edge_stb}, 32'd0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk);
        chk("R1 clk_out after reset", {31'd0, clk_out}, 32'd0);

        // R4: period 0 acts as 1, strobe every running cycle
        write_cfg(32'h0000_0000, 1'b1, 32'h8000_0000, 1'b0);
        enable = 1'b1;
        @(negedge clk);
        count_stb(8, c);
        chk("R4 period zero adds every clock", c, 8);

        // R9: half-scale step with period 3
        write_cfg(32'h0000_0003, 1'b0, 32'h0, 1'b0);
        enable = 1'b1;
        @(negedge clk);
        count_stb(30, c);
        chk("R9 toggle count period 3", c, toggles_expected(30, 3));

        // R3: new increment changes the rate
        write_cfg(32'h0000_0001, 1'b1, 32'h4000_0000, 1'b0);
        enable = 1'b1;
        @(negedge clk);
        count_stb(20, c);
        chk("R3 quarter step halves rate", c, 10);

        // R2: phase preset puts output high from the first running cycle
        write_cfg(32'h8000_0005, 1'b1, 32'h0, 1'b0);
        chk("R5 low while off", {31'd0, clk_out}, 32'd0);
        enable = 1'b1;
        @(negedge clk);
        chk("R2 preset output high", {31'd0, clk_out}, 32'd1);
        count_stb(12, c);
        chk("R2 zero increment holds phase", c, 0);

        // R6: stop freezes phase, restart resumes it
        write_cfg(32'h0000_0001, 1'b1, 32'h8000_0000, 1'b0);
        enable = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R4 first add one edge after start", {31'd0, clk_out}, 32'd1);
        enable = 1'b0;
        repeat (4) begin
            @(negedge clk);
            chk("R6 output low while stopped", {31'd0, clk_out}, 32'd0);
            chk("R6 no strobe while stopped", {31'd0, edge_stb}, 32'd0);
        end
        enable = 1'b1;
        @(negedge clk);
        chk("R6 resumes frozen phase", {31'd0, clk_out}, 32'd1);

        // R8: configuration write wins over a due add
        while (clk_out != 1'b0) @(negedge clk);
        write_cfg(32'h0000_0001, 1'b0, 32'h0, 1'b1);
        chk("R8 no add on cfg edge", {31'd0, clk_out}, 32'd0);
        chk("R8 no strobe on cfg edge", {31'd0, edge_stb}, 32'd0);
        @(negedge clk);
        chk("R8 count restarts, next add", {31'd0, clk_out}, 32'd1);
        chk("R7 strobe on that edge", {31'd0, edge_stb}, 32'd1);

        // Random phase checked against the model
        for (int i = 0; i < 4000; i++) begin
            enable = ($urandom % 8) != 0;
            cfg_wr = ($urandom % 24) == 0;
            cfg_x  = {16'($urandom), 16'($urandom % 5)};
            inc_wr = ($urandom % 10) == 0;
            inc_val = $urandom;
            @(negedge clk);
        end
        cfg_wr = 1'b0; inc_wr = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (R1..all): actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule